// File: doc/BRIEF.md
# Bridge Configuration Cycle Router

This block sits on the upstream side of a bus-to-bus bridge and decides what happens to each configuration cycle arriving there. A configuration cycle is a 32-bit address with a type flag and a valid strobe. A cycle of the routed type carries a target bus number, and the block compares that number against the bridge's programmed secondary and subordinate bus numbers. The result is one of three actions:

- **Ignore:** the cycle is dropped.
- **Convert:** the cycle is rewritten as a local cycle for the bus directly behind the bridge. The device number becomes a one-hot select in the upper address bits.
- **Pass:** the cycle is forwarded downstream unchanged.

Three 8-bit bus-number registers hold the upstream, secondary and subordinate numbers. They are written through a simple select/data/enable port, and their values are also driven out for neighbouring logic. Every valid input cycle produces exactly one registered result one clock later. That result is an action code, the downstream address and its type flag. Data transfer and completion handling live elsewhere.

Top module: `cfg_cycle_router`

## Requirements
- R1: A routed cycle (type flag 1) whose bus number, address bits 23:16, is below the secondary number or above the subordinate number gets action 0 (ignore). When subordinate is below secondary, every such cycle is ignored.
- R2: A routed cycle whose bus number equals the secondary number gets action 1 (convert). The output type flag is 0, output bits 10:2 equal input bits 10:2, and output bits 1:0 are 00.
- R3: A routed cycle whose bus number is greater than secondary and no greater than subordinate gets action 2 (pass). The output address equals the input address and the output type flag is 1.
- R4: A local cycle (type flag 0) is always ignored, whatever its address.
- R5: In a converted cycle, device number d (input bits 15:11) sets output bit 11+d, and every other bit in 31:11 is zero.
- R6: A cycle that would convert but has a device number above 20 is ignored instead.
- R7: A subordinate value of 0xFF is accepted, so every bus number from secondary up to 0xFF is claimed.
- R8: After reset all three bus numbers read 0 and out_valid_o is low. While the secondary number is 0, every cycle is ignored.
- R9: out_valid_o is high exactly one cycle after each cycle where cyc_valid_i is high, and low otherwise. The action code is never 3. An ignored cycle drives out_addr_o = 0 and out_type1_o = 0.
- R10: When cfg_we_i is high, cfg_sel_i picks the register to write: 0 writes upstream, 1 writes secondary, 2 writes subordinate, and 3 writes nothing. The new value appears on the bus outputs after that clock edge and governs cycles presented afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Bus-number register write enable |
| cfg_sel_i | input | 2 | Register select: 0 upstream, 1 secondary, 2 subordinate, 3 none |
| cfg_wdata_i | input | 8 | Bus-number write value |
| cyc_valid_i | input | 1 | Input cycle valid |
| cyc_type1_i | input | 1 | 1 = routed cycle carrying a bus number, 0 = local cycle |
| cyc_addr_i | input | 32 | Input configuration address |
| out_valid_o | output | 1 | Result valid, one cycle after the input |
| out_action_o | output | 2 | 0 ignore, 1 convert, 2 pass |
| out_type1_o | output | 1 | Type flag of the downstream cycle |
| out_addr_o | output | 32 | Downstream address |
| pri_bus_o | output | 8 | Upstream bus number register |
| sec_bus_o | output | 8 | Secondary bus number register |
| sub_bus_o | output | 8 | Subordinate bus number register |

## Verification
The bench tests the range edges directly:
- **Bus numbers one below secondary, at secondary, at subordinate and one above it.** An off-by-one comparison would pass or convert a cycle that belongs elsewhere.
- **Device numbers 0, 20 and 21.** A select shifted from bit 11 would hit the wrong slot, and a missing limit would wrap a select bit out of the field.
- **Subordinate 0xFF and an inverted range.** An overflowing comparison would drop the top bus or claim cycles from an empty range.
- **Reset values and select 3.** These cover an unprogrammed bridge that answers bus 0 and a stray register write.

Random cycles biased toward these edges are then compared against a reference function.

// File: rtl/cfg_route_pkg.sv
package cfg_route_pkg;
  typedef enum logic [1:0] {
    ACT_IGNORE  = 2'd0,
    ACT_CONVERT = 2'd1,
    ACT_PASS    = 2'd2
  } route_act_e;

  localparam int unsigned NUM_BUS_REGS = 3;
endpackage

// File: rtl/bus_num_regs.sv
module bus_num_regs #(
  parameter int unsigned BUS_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       sel_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic [BUS_W-1:0] pri_o,
  output logic [BUS_W-1:0] sec_o,
  output logic [BUS_W-1:0] sub_o
);
  import cfg_route_pkg::*;

  logic [BUS_W-1:0] regs_q [NUM_BUS_REGS];

  for (genvar g = 0; g < NUM_BUS_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        regs_q[g] <= '0;
      end else if (we_i && (sel_i == 2'(g))) begin
        regs_q[g] <= wdata_i;
      end
    end
  end

  assign pri_o = regs_q[0];
  assign sec_o = regs_q[1];
  assign sub_o = regs_q[2];
endmodule

// File: rtl/bus_range_cmp.sv
module bus_range_cmp #(
  parameter int unsigned BUS_W = 8
) (
  input  logic [BUS_W-1:0] bus_i,
  input  logic [BUS_W-1:0] sec_i,
  input  logic [BUS_W-1:0] sub_i,
  output logic             local_o,
  output logic             fwd_o
);
  logic armed, ge_sec, le_sub;

  // secondary 0 means the bridge is not yet numbered
  assign armed   = (sec_i != '0);
  assign ge_sec  = (bus_i >= sec_i);
  assign le_sub  = (bus_i <= sub_i);
  assign local_o = armed && le_sub && (bus_i == sec_i);
  assign fwd_o   = armed && le_sub && ge_sec && (bus_i != sec_i);
endmodule

// File: rtl/type0_encoder.sv
module type0_encoder #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned DEV_LSB = 11,
  parameter int unsigned DEV_W   = 5
) (
  input  logic [DEV_W-1:0]     dev_i,
  input  logic [DEV_LSB-3:0]   low_i,
  output logic [ADDR_W-1:0]    addr_o,
  output logic                 dev_ok_o
);
  localparam int unsigned SEL_W   = ADDR_W - DEV_LSB;
  localparam int unsigned DEV_MAX = SEL_W - 1;

  logic [SEL_W-1:0] sel;

  for (genvar k = 0; k < SEL_W; k++) begin : g_sel
    assign sel[k] = (dev_i == DEV_W'(k));
  end

  assign dev_ok_o = (32'(dev_i) <= DEV_MAX);
  assign addr_o   = {sel, low_i, 2'b00};
endmodule

// File: rtl/cfg_cycle_router.sv
module cfg_cycle_router #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned BUS_W   = 8,
  parameter int unsigned BUS_LSB = 16,
  parameter int unsigned DEV_LSB = 11,
  parameter int unsigned DEV_W   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic [BUS_W-1:0]  cfg_wdata_i,
  input  logic              cyc_valid_i,
  input  logic              cyc_type1_i,
  input  logic [ADDR_W-1:0] cyc_addr_i,
  output logic              out_valid_o,
  output logic [1:0]        out_action_o,
  output logic              out_type1_o,
  output logic [ADDR_W-1:0] out_addr_o,
  output logic [BUS_W-1:0]  pri_bus_o,
  output logic [BUS_W-1:0]  sec_bus_o,
  output logic [BUS_W-1:0]  sub_bus_o
);
  import cfg_route_pkg::*;

  logic [BUS_W-1:0]  bus_num;
  logic              is_local, is_fwd, dev_ok;
  logic [ADDR_W-1:0] t0_addr;

  route_act_e        act_d, act_q;
  logic [ADDR_W-1:0] addr_d, addr_q;
  logic              t1_d, t1_q, valid_q;

  assign bus_num = cyc_addr_i[BUS_LSB +: BUS_W];

  bus_num_regs #(.BUS_W(BUS_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .sel_i   (cfg_sel_i),
    .wdata_i (cfg_wdata_i),
    .pri_o   (pri_bus_o),
    .sec_o   (sec_bus_o),
    .sub_o   (sub_bus_o)
  );

  bus_range_cmp #(.BUS_W(BUS_W)) u_cmp (
    .bus_i   (bus_num),
    .sec_i   (sec_bus_o),
    .sub_i   (sub_bus_o),
    .local_o (is_local),
    .fwd_o   (is_fwd)
  );

  type0_encoder #(.ADDR_W(ADDR_W), .DEV_LSB(DEV_LSB), .DEV_W(DEV_W)) u_enc (
    .dev_i    (cyc_addr_i[DEV_LSB +: DEV_W]),
    .low_i    (cyc_addr_i[DEV_LSB-1:2]),
    .addr_o   (t0_addr),
    .dev_ok_o (dev_ok)
  );

  always_comb begin
    act_d  = ACT_IGNORE;
    addr_d = '0;
    t1_d   = 1'b0;
    if (cyc_type1_i) begin
      if (is_fwd) begin
        act_d  = ACT_PASS;
        addr_d = cyc_addr_i;
        t1_d   = 1'b1;
      end else if (is_local && dev_ok) begin
        act_d  = ACT_CONVERT;
        addr_d = t0_addr;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      act_q   <= ACT_IGNORE;
      addr_q  <= '0;
      t1_q    <= 1'b0;
    end else begin
      valid_q <= cyc_valid_i;
      if (cyc_valid_i) begin
        act_q  <= act_d;
        addr_q <= addr_d;
        t1_q   <= t1_d;
      end
    end
  end

  assign out_valid_o  = valid_q;
  assign out_action_o = act_q;
  assign out_type1_o  = t1_q;
  assign out_addr_o   = addr_q;
endmodule

// File: rtl/cfg_cycle_router_chk.sv
module cfg_cycle_router_chk #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned BUS_W   = 8,
  parameter int unsigned DEV_LSB = 11,
  parameter int unsigned DEV_W   = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cyc_valid_i,
  input logic              cyc_type1_i,
  input logic [BUS_W-1:0]  bus_i,
  input logic [DEV_W-1:0]  dev_i,
  input logic              out_valid_o,
  input logic [1:0]        out_action_o,
  input logic              out_type1_o,
  input logic [ADDR_W-1:0] out_addr_o,
  input logic [BUS_W-1:0]  sec_bus_o,
  input logic [BUS_W-1:0]  sub_bus_o
);
  localparam int unsigned SEL_W = ADDR_W - DEV_LSB;

  logic [DEV_W-1:0] dev_q;
  logic armed;
  assign armed = cyc_valid_i && cyc_type1_i && (sec_bus_o != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dev_q <= '0;
    else         dev_q <= dev_i;
  end

  // R1
  out_of_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_valid_i && ((bus_i < sec_bus_o) || (bus_i > sub_bus_o))) |=> (out_action_o == 2'd0));

  // R2
  convert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && bus_i == sec_bus_o && bus_i <= sub_bus_o && 32'(dev_i) < SEL_W)
    |=> (out_action_o == 2'd1 && !out_type1_o && out_addr_o[1:0] == 2'b00));

  // R3
  pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && bus_i > sec_bus_o && bus_i <= sub_bus_o)
    |=> (out_action_o == 2'd2 && out_type1_o));

  // R4
  local_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_valid_i && !cyc_type1_i) |=> (out_action_o == 2'd0));

  // R5
  onehot_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_action_o == 2'd1)
    |-> (out_addr_o[ADDR_W-1:DEV_LSB] == (SEL_W'(1) << dev_q)));

  // R6
  dev_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_valid_i && 32'(dev_i) >= SEL_W && bus_i == sec_bus_o) |=> (out_action_o != 2'd1));

  // R8
  unnumbered_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_valid_i && sec_bus_o == '0) |=> (out_action_o == 2'd0));

  // R9
  valid_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_valid_i |=> out_valid_o);

  // R9
  valid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cyc_valid_i |=> !out_valid_o);

  // R9
  legal_action_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_action_o != 2'd3));

  // R9
  ignore_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_action_o == 2'd0) |-> (out_addr_o == '0 && !out_type1_o));
endmodule

bind cfg_cycle_router cfg_cycle_router_chk #(
  .ADDR_W(ADDR_W), .BUS_W(BUS_W), .DEV_LSB(DEV_LSB), .DEV_W(DEV_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cyc_valid_i  (cyc_valid_i),
  .cyc_type1_i  (cyc_type1_i),
  .bus_i        (cyc_addr_i[BUS_LSB +: BUS_W]),
  .dev_i        (cyc_addr_i[DEV_LSB +: DEV_W]),
  .out_valid_o  (out_valid_o),
  .out_action_o (out_action_o),
  .out_type1_o  (out_type1_o),
  .out_addr_o   (out_addr_o),
  .sec_bus_o    (sec_bus_o),
  .sub_bus_o    (sub_bus_o)
);

// File: tb/cfg_cycle_router_tb.sv
module cfg_cycle_router_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [7:0]  cfg_wdata = 8'd0;
  logic        cyc_valid = 1'b0;
  logic        cyc_type1 = 1'b0;
  logic [31:0] cyc_addr = 32'd0;
  logic        out_valid;
  logic [1:0]  out_action;
  logic        out_type1;
  logic [31:0] out_addr;
  logic [7:0]  pri_bus, sec_bus, sub_bus;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [7:0] m_pri = 0, m_sec = 0, m_sub = 0;

  always #5 clk = ~clk;

  cfg_cycle_router u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata),
    .cyc_valid_i(cyc_valid), .cyc_type1_i(cyc_type1), .cyc_addr_i(cyc_addr),
    .out_valid_o(out_valid), .out_action_o(out_action),
    .out_type1_o(out_type1), .out_addr_o(out_addr),
    .pri_bus_o(pri_bus), .sec_bus_o(sec_bus), .sub_bus_o(sub_bus)
  );

  // {action, type1, addr}
  function automatic logic [34:0] ref_route(logic [7:0] sec, logic [7:0] sub,
                                            logic t1, logic [31:0] a);
    logic [7:0] bus = a[23:16];
    logic [4:0] dev = a[15:11];
    if (!t1 || sec == 0 || bus < sec || bus > sub) return {2'd0, 1'b0, 32'd0};
    if (bus == sec) begin
      if (dev > 20) return {2'd0, 1'b0, 32'd0};
      return {2'd1, 1'b0, (32'd1 << (11 + dev)) | {21'd0, a[10:2], 2'b00}};
    end
    return {2'd2, 1'b1, a};
  endfunction

  function automatic logic [31:0] mk(logic [7:0] hi, logic [7:0] bus, logic [4:0] dev,
                                     logic [2:0] fn, logic [5:0] rg);
    return {hi, bus, dev, fn, rg, 2'b01};
  endfunction

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [7:0] val);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel == 2'd0) m_pri = val;
    else if (sel == 2'd1) m_sec = val;
    else if (sel == 2'd2) m_sub = val;
  endtask

  task automatic chk_regs(string req);
    check(pri_bus == m_pri && sec_bus == m_sec && sub_bus == m_sub, req, "bus regs",
          {40'd0, pri_bus, sec_bus, sub_bus}, {40'd0, m_pri, m_sec, m_sub});
  endtask

  task automatic send(logic t1, logic [31:0] a, string req);
    logic [34:0] e = ref_route(m_sec, m_sub, t1, a);
    cyc_valid = 1'b1; cyc_type1 = t1; cyc_addr = a;
    @(negedge clk);
    cyc_valid = 1'b0;
    check(out_valid == 1'b1, req, "valid", {63'd0, out_valid}, 64'd1);
    check({out_action, out_type1, out_addr} == e, req, "result",
          {29'd0, out_action, out_type1, out_addr}, {29'd0, e});
  endtask

  task automatic idle_chk(string req);
    @(negedge clk);
    check(out_valid == 1'b0, req, "idle valid", {63'd0, out_valid}, 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R8 reset state
    check(out_valid == 1'b0, "R8", "reset valid", {63'd0, out_valid}, 64'd0);
    chk_regs("R8");
    rst_n = 1'b1;
    @(negedge clk);
    send(1'b1, mk(8'h00, 8'h00, 5'd0, 3'd0, 6'd0), "R8");
    send(1'b1, mk(8'h00, 8'h05, 5'd1, 3'd0, 6'd0), "R8");
    idle_chk("R9");

    // R10 programming and select 3
    wr(2'd0, 8'h00); wr(2'd1, 8'h01); wr(2'd2, 8'hFF);
    chk_regs("R10");
    wr(2'd3, 8'h77);
    chk_regs("R10");

    // R7 sub 0xFF claims everything from secondary upward
    send(1'b1, mk(8'h00, 8'hFF, 5'd3, 3'd1, 6'd2), "R7");
    send(1'b1, mk(8'hA5, 8'h02, 5'd9, 3'd7, 6'd63), "R3");
    send(1'b1, mk(8'h00, 8'h00, 5'd0, 3'd0, 6'd0), "R1");
    // R5 / R2 / R6 select edges
    send(1'b1, mk(8'h00, 8'h01, 5'd0, 3'd5, 6'd17), "R5");
    send(1'b1, mk(8'h00, 8'h01, 5'd20, 3'd2, 6'd4), "R5");
    send(1'b1, mk(8'h00, 8'h01, 5'd7, 3'd3, 6'd40), "R2");
    send(1'b1, mk(8'h00, 8'h01, 5'd21, 3'd0, 6'd0), "R6");
    send(1'b1, mk(8'h00, 8'h01, 5'd31, 3'd0, 6'd0), "R6");
    // R4 local cycle
    send(1'b0, mk(8'h00, 8'h01, 5'd2, 3'd0, 6'd0), "R4");
    send(1'b0, 32'hFFFF_FFFF, "R4");

    // narrow range
    wr(2'd1, 8'h03); wr(2'd2, 8'h04);
    chk_regs("R10");
    send(1'b1, mk(8'h00, 8'h02, 5'd1, 3'd0, 6'd0), "R1");
    send(1'b1, mk(8'h00, 8'h03, 5'd1, 3'd0, 6'd0), "R2");
    send(1'b1, mk(8'h00, 8'h04, 5'd1, 3'd0, 6'd0), "R3");
    send(1'b1, mk(8'h00, 8'h05, 5'd1, 3'd0, 6'd0), "R1");
    // inverted range
    wr(2'd1, 8'h05); wr(2'd2, 8'h03);
    send(1'b1, mk(8'h00, 8'h05, 5'd1, 3'd0, 6'd0), "R1");
    send(1'b1, mk(8'h00, 8'h04, 5'd1, 3'd0, 6'd0), "R1");
    idle_chk("R9");

    for (int i = 0; i < 600; i++) begin
      logic [7:0]  bus;
      logic [31:0] a;
      int unsigned pick;
      if (($urandom % 16) == 0) begin
        wr(2'd1, 8'($urandom % 6));
        wr(2'd2, (($urandom % 4) == 0) ? 8'hFF : 8'(m_sec + ($urandom % 4)));
      end
      pick = $urandom % 6;
      case (pick)
        0: bus = m_sec - 8'd1;
        1, 2: bus = m_sec;
        3: bus = m_sub;
        4: bus = m_sub + 8'd1;
        default: bus = 8'($urandom);
      endcase
      a = mk(8'($urandom), bus, 5'($urandom), 3'($urandom), 6'($urandom));
      send(($urandom % 8) != 0, a, "R9");
      if (($urandom % 8) == 0) idle_chk("R9");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule